// File: doc/BRIEF.md
# Call-Charge Detector Settings Block

This block supplies the operating settings of a two-channel call-charge tone detector: one bit choosing the 12 kHz or 16 kHz detection frequency, and one sensitivity code per channel. The downstream detection logic reads these three values continuously. They come from one of two sources, chosen by a strap pin.

With the strap pin high, the settings are pin-strapped. A system-select pin picks the frequency, and both channels use a fixed sensitivity code given as a parameter. With the strap pin low, a host loads the settings over a three-wire serial port made of an active-low select, a clock and a data line. A loaded word sits in a shadow shift register. It reaches the controlled-mode registers only when the select is released after a complete word.

All five pins are asynchronous to the system clock. Each passes through a two-flop synchroniser before any edge detection, and the three settings outputs are registered.

Top module: `spm_cfg_top`

## Requirements
- R1: With the strap pin high, `freq_12k_o` equals the synchronised system-select pin (1 = 12 kHz, 0 = 16 kHz), and both sensitivity outputs equal `FIXED_SENS` (default 32).
- R2: With the strap pin low, the outputs show the controlled-mode registers, and the system-select pin has no effect on any output.
- R3: A serial word is 16 bits, shifted MSB first. Data is sampled on each rising edge of the serial clock while the select is low. Bit 15 is the frequency bit (1 = 12 kHz), bits 14:8 are the channel-2 sensitivity, bit 7 is ignored, and bits 6:0 are the channel-1 sensitivity.
- R4: The controlled registers take the shadow word only on a rising edge of the select, and only if exactly 16 serial clock rising edges arrived while it was low. With 0, 15 or 17 edges, the previous settings are kept.
- R5: After reset, the outputs show 12 kHz and `FIXED_SENS`. The controlled registers hold 12 kHz and mid-scale sensitivity (64 on both channels).
- R6: A word loaded while the strap pin is high is kept, and it appears at the outputs once the strap pin goes low. Changing the strap pin does not alter the controlled registers.
- R7: The serial bit counter never exceeds 17. The shadow register holds its value while the select is high.
- R8: The outputs follow a change of the strap or system-select pin within 3 system clock cycles, and follow a completed load within 4 cycles of the select rising.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_fixed_i | input | 1 | Source select: 1 = pin-strapped settings, 0 = serial settings |
| sys_sel_i | input | 1 | Frequency pin in strapped mode: 1 = 12 kHz, 0 = 16 kHz |
| ser_cs_n_i | input | 1 | Serial select, active low |
| ser_clk_i | input | 1 | Serial clock; data sampled on its rising edge |
| ser_dat_i | input | 1 | Serial data, MSB first |
| freq_12k_o | output | 1 | Active frequency: 1 = 12 kHz, 0 = 16 kHz |
| sens_ch1_o | output | SENS_W | Channel-1 sensitivity code |
| sens_ch2_o | output | SENS_W | Channel-2 sensitivity code |

## Verification
Most internal faults are invisible until the strap pin goes low. A wrong bit counter, shadow register or load gate shows up as a stale or misaligned word on the sensitivity outputs within four cycles of the select rising. Words that are one edge short or one edge long are the cases that expose an off-by-one in the count check. A wrong source mux or fixed default shows up within three cycles of a strap pin change. For that reason, the bench toggles the strap pin and the system-select pin between loads, so that both sources and the ignored pin are observed at the ports.

// File: rtl/spm_cfg_pkg.sv
package spm_cfg_pkg;
  typedef enum logic {
    FREQ_16K = 1'b0,
    FREQ_12K = 1'b1
  } freq_e;

  typedef enum logic {
    SRC_SERIAL = 1'b0,
    SRC_STRAP  = 1'b1
  } src_e;
endpackage

// File: rtl/spm_sync.sv
module spm_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stage_q[0] <= RST_VAL;
    else     stage_q[0] <= d_i;
  end

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spm_serial_rx.sv
module spm_serial_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              sdat_s,
  output logic              load_o,
  output logic [WORD_W-1:0] word_o
);
  localparam int CNT_MAX = WORD_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic              sclk_d, cs_d;
  logic [CNT_W-1:0]  cnt_q;
  logic [WORD_W-1:0] shift_q;
  logic              sclk_rise, cs_rise, selected;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = cs_n_s & ~cs_d;
  assign selected  = ~cs_n_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      cnt_q   <= '0;
      shift_q <= '0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_n_s;
      if (!selected) begin
        cnt_q <= '0;
      end else if (sclk_rise) begin
        shift_q <= {shift_q[WORD_W-2:0], sdat_s};
        if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign load_o = cs_rise && (cnt_q == CNT_W'(WORD_W));
  assign word_o = shift_q;

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(CNT_MAX));
  p_shadow_hold_r7: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> $stable(shift_q));
endmodule

// File: rtl/spm_ctl_bank.sv
module spm_ctl_bank #(
  parameter int SENS_W = 7,
  parameter int WORD_W = 2 * SENS_W + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              freq_o,
  output logic [SENS_W-1:0] sens1_o,
  output logic [SENS_W-1:0] sens2_o
);
  import spm_cfg_pkg::*;
  localparam logic [SENS_W-1:0] MID = SENS_W'(1) << (SENS_W - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_o  <= FREQ_12K;
      sens1_o <= MID;
      sens2_o <= MID;
    end else if (load_i) begin
      freq_o  <= word_i[WORD_W-1];
      sens2_o <= word_i[WORD_W-2 -: SENS_W];
      sens1_o <= word_i[SENS_W-1:0];
    end
  end
endmodule

// File: rtl/spm_cfg_top.sv
module spm_cfg_top #(
  parameter int SENS_W = 7,
  parameter int SYNC_STAGES = 2,
  parameter logic [SENS_W-1:0] FIXED_SENS = SENS_W'(32)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_fixed_i,
  input  logic              sys_sel_i,
  input  logic              ser_cs_n_i,
  input  logic              ser_clk_i,
  input  logic              ser_dat_i,
  output logic              freq_12k_o,
  output logic [SENS_W-1:0] sens_ch1_o,
  output logic [SENS_W-1:0] sens_ch2_o
);
  import spm_cfg_pkg::*;
  localparam int WORD_W = 2 * SENS_W + 2;

  logic [4:0]        pins_s;
  logic              strap_s, sys_s, cs_n_s, sclk_s, sdat_s;
  logic              load;
  logic [WORD_W-1:0] word;
  logic              ctl_freq;
  logic [SENS_W-1:0] ctl_s1, ctl_s2;
  src_e              src;

  spm_sync #(.WIDTH(5), .STAGES(SYNC_STAGES), .RST_VAL(5'b11100)) u_sync (
    .clk(clk), .rst(rst),
    .d_i({strap_fixed_i, sys_sel_i, ser_cs_n_i, ser_clk_i, ser_dat_i}),
    .q_o(pins_s)
  );
  assign {strap_s, sys_s, cs_n_s, sclk_s, sdat_s} = pins_s;
  assign src = src_e'(strap_s);

  spm_serial_rx #(.WORD_W(WORD_W)) u_rx (
    .clk(clk), .rst(rst), .cs_n_s(cs_n_s), .sclk_s(sclk_s), .sdat_s(sdat_s),
    .load_o(load), .word_o(word)
  );

  spm_ctl_bank #(.SENS_W(SENS_W), .WORD_W(WORD_W)) u_bank (
    .clk(clk), .rst(rst), .load_i(load), .word_i(word),
    .freq_o(ctl_freq), .sens1_o(ctl_s1), .sens2_o(ctl_s2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      freq_12k_o <= FREQ_12K;
      sens_ch1_o <= FIXED_SENS;
      sens_ch2_o <= FIXED_SENS;
    end else if (src == SRC_STRAP) begin
      freq_12k_o <= sys_s;
      sens_ch1_o <= FIXED_SENS;
      sens_ch2_o <= FIXED_SENS;
    end else begin
      freq_12k_o <= ctl_freq;
      sens_ch1_o <= ctl_s1;
      sens_ch2_o <= ctl_s2;
    end
  end

  p_fixed_src_r1: assert property (@(posedge clk) disable iff (rst)
    strap_s |=> (freq_12k_o == $past(sys_s) && sens_ch1_o == FIXED_SENS
                 && sens_ch2_o == FIXED_SENS));
  p_serial_src_r2: assert property (@(posedge clk) disable iff (rst)
    !strap_s |=> (freq_12k_o == $past(ctl_freq) && sens_ch1_o == $past(ctl_s1)
                  && sens_ch2_o == $past(ctl_s2)));
  p_load_gate_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable({ctl_freq, ctl_s1, ctl_s2}) |-> $past(load));
  p_load_only_on_release_r4: assert property (@(posedge clk) disable iff (rst)
    load |-> cs_n_s);
endmodule

// File: tb/spm_cfg_top_tb_top.sv
module spm_cfg_top_tb_top;
  localparam int SW = 7;
  localparam logic [SW-1:0] FIX = 7'd32;

  logic clk = 1'b0, rst = 1'b1;
  logic strap = 1'b1, sys = 1'b1, cs_n = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic freq_o;
  logic [SW-1:0] s1_o, s2_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [15:0] ctl_m = {1'b1, 7'd64, 1'b0, 7'd64};

  always #10 clk = ~clk;

  spm_cfg_top #(.SENS_W(SW), .FIXED_SENS(FIX)) dut_i (
    .clk(clk), .rst(rst), .strap_fixed_i(strap), .sys_sel_i(sys),
    .ser_cs_n_i(cs_n), .ser_clk_i(sclk), .ser_dat_i(sdat),
    .freq_12k_o(freq_o), .sens_ch1_o(s1_o), .sens_ch2_o(s2_o)
  );

  function automatic logic [2*SW:0] expect_out(logic st, logic sy, logic [15:0] c);
    if (st) return {sy, FIX, FIX};
    return {c[15], c[6:0], c[14:8]};
  endfunction

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(string req);
    logic [2*SW:0] exp, act;
    exp = expect_out(strap, sys, ctl_m);
    act = {freq_o, s1_o, s2_o};
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: act freq=%0b s1=%0d s2=%0d exp freq=%0b s1=%0d s2=%0d",
               req, act[2*SW], act[2*SW-1 -: SW], act[SW-1:0],
               exp[2*SW], exp[2*SW-1 -: SW], exp[SW-1:0]);
    end
  endtask

  task automatic send(logic [16:0] w, int nb);
    @(negedge clk); cs_n = 1'b0; wait_clk(4);
    for (int i = nb - 1; i >= 0; i--) begin
      sdat = w[i]; wait_clk(4);
      sclk = 1'b1; wait_clk(4);
      sclk = 1'b0;
    end
    wait_clk(4); cs_n = 1'b1; wait_clk(8);
    if (nb == 16) ctl_m = w[15:0];
  endtask

  initial begin
    void'($urandom(32'd641));
    wait_clk(3); rst = 1'b0; wait_clk(1);
    check("R5 reset outputs");
    wait_clk(4); check("R5 strapped default 12k");
    strap = 1'b0; wait_clk(3); check("R5 controlled reset mid-scale");
    sys = 1'b0; wait_clk(4); check("R2 sys-select ignored");
    send(17'h0A581, 16); check("R3 word layout");
    send(17'h0FFFF, 15); check("R4 15 edges kept");
    send(17'h1FFFF, 17); check("R4 17 edges kept");
    send(17'h0, 0); check("R4 no edges kept");
    send(17'h07F00, 16); check("R3 16k ch2 max ch1 zero");
    strap = 1'b1; wait_clk(3); check("R8 strap latency R1 16k");
    sys = 1'b1; wait_clk(3); check("R1 12k");
    send(17'h0827F, 16); check("R6 load while strapped hidden");
    strap = 1'b0; wait_clk(3); check("R6 stored word shown");
    for (int k = 0; k < 40; k++) begin
      logic [16:0] w;
      int sel, nb;
      w = 17'($urandom);
      sel = $urandom_range(0, 3);
      nb = (sel == 0) ? 15 : (sel == 1) ? 17 : 16;
      send(w, nb);
      check(nb == 16 ? "R3 random load" : "R4 random bad length");
      strap = 1'($urandom); sys = 1'($urandom); wait_clk(3);
      check(strap ? "R1 random strap" : "R2 random serial");
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: act=hung exp=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule